// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block loads a configuration bitstream into a programmable target over a five-wire passive serial link. The link has an active-low configuration reset, a serial data line, a serial clock, a status line coming back from the target and a done line coming back from the target. Bitstream bytes arrive on a valid/ready byte stream. The last byte is marked with a flag. The block neither stores nor interprets the bitstream.

A start request runs the whole load. The block holds the target in reset, releases it, waits, and then confirms that the target reports healthy status. It then shifts every byte out least-significant bit first and checks status again at the end of each byte. After the last byte it parks the data line low, lets it settle, and requires the done line to be high. A fixed delay after done follows before it reports the target as configured. A failure at any step ends the run with a two-bit error code, which stays valid until the next start. A separate unload request puts the target back into reset and then releases all three driven pins to high impedance.

All waits are counted in pulses of a one-microsecond tick input. The serial clock runs at half the system clock, with one cycle low and one cycle high per bit.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset, pinOe is 0, cfgResetN is 1, busy is 0, inReady is 0, configured is 0 and errCode is 0.
- R2: A start request accepted while idle drives cfgResetN low for exactly RESET_LOW_US tick pulses. Exactly RESET_WAIT_US tick pulses then pass with cfgResetN high before inReady first rises.
- R3: If statusIn is low when the reset wait ends, the run stops with errCode 1, and no byte is ever accepted.
- R4: Each byte is sent as 8 bits, least-significant first. dataOut is stable in the cycle before every rising edge of clkOut. clkOut stays high for exactly one cycle and otherwise idles low.
- R5: inReady is high only while the block waits for a byte, never while a byte is being shifted. Each handshake transfers exactly one byte, in stream order. A byte with inLast high ends the stream.
- R6: If statusIn is low at the end of any byte, the run stops with errCode 2, and no further byte is accepted.
- R7: After the last byte, dataOut is driven low. After SETTLE_US tick pulses, doneIn is sampled, and a low value ends the run with errCode 3 and configured left at 0.
- R8: If doneIn is high at that sample, configured rises after USER_WAIT_US further tick pulses and errCode stays 0. Counted from the final fall of clkOut, this is 41 or 42 pulses with the default parameters.
- R9: An unload request accepted while idle clears configured and drives cfgResetN low with pinOe high for exactly UNLOAD_US tick pulses. After that, pinOe returns to 0.
- R10: Start and unload requests are ignored while busy is high. errCode holds its value while idle and is cleared to 0 when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| usTick | input | 1 | One-cycle pulse every microsecond |
| startReq | input | 1 | Begin a configuration run (accepted while idle) |
| unloadReq | input | 1 | Return the target to reset and release the pins (accepted while idle) |
| inData | input | BYTE_W | Bitstream byte |
| inValid | input | 1 | inData is valid |
| inLast | input | 1 | Marks the final byte of the bitstream |
| inReady | output | 1 | Block accepts a byte this cycle |
| statusIn | input | 1 | Target status line, high means healthy |
| doneIn | input | 1 | Target done line |
| cfgResetN | output | 1 | Active-low configuration reset to the target |
| dataOut | output | 1 | Serial data to the target |
| clkOut | output | 1 | Serial clock to the target |
| pinOe | output | 1 | Output enable for cfgResetN, dataOut and clkOut |
| busy | output | 1 | A run or an unload is in progress |
| configured | output | 1 | Target loaded and in user mode |
| errCode | output | 2 | 0 ok, 1 reset failure, 2 status lost, 3 done missing |

## Verification
A wrong sequencer state shows at the pins within one or two cycles. A stray or missing clkOut pulse, or a bit in the wrong order, corrupts the byte that a target model rebuilds from rising clkOut edges, and that byte is compared as soon as it completes. A delay counter that is off by one changes the number of tick pulses seen while cfgResetN is low, or seen before inReady or configured rises, so each wait is measured in ticks at the pins. A missed status or done check shows up as a wrong errCode, as a byte accepted after the failure, or as configured rising when it should not.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_LOW, S_RST_WAIT, S_STAT_CHK, S_FETCH, S_BIT_HIGH,
    S_BIT_LOW, S_BYTE_CHK, S_SETTLE, S_DONE_CHK, S_USER_WAIT, S_UNLOAD
  } seqState_t;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_RESET  = 2'd1,
    ERR_STATUS = 2'd2,
    ERR_DONE   = 2'd3
  } errCode_t;

  // strobes from the sequencer to the pin datapath
  typedef struct packed {
    logic driveOn;
    logic tristate;
    logic resetAssert;
    logic resetRelease;
    logic loadByte;
    logic clkRise;
    logic clkFall;
    logic shiftBit;
    logic dataClear;
  } pinStrobe_t;

endpackage

// File: rtl/ps_cfg_datapath.sv
module ps_cfg_datapath
  import ps_cfg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pinStrobe_t        stb,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  output logic              cfgResetN,
  output logic              dataOut,
  output logic              clkOut,
  output logic              pinOe,
  output logic              lastFlag,
  output logic              lastBit
);
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic [BYTE_W-1:0] shiftReg;
  logic [IDX_W-1:0]  bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinOe     <= 1'b0;
      cfgResetN <= 1'b1;
      dataOut   <= 1'b0;
      clkOut    <= 1'b0;
      shiftReg  <= '0;
      bitIdx    <= '0;
      lastFlag  <= 1'b0;
    end else begin
      if (stb.driveOn)      pinOe <= 1'b1;
      if (stb.tristate) begin
        pinOe     <= 1'b0;
        cfgResetN <= 1'b1;
      end
      if (stb.resetAssert)  cfgResetN <= 1'b0;
      if (stb.resetRelease) cfgResetN <= 1'b1;
      if (stb.loadByte) begin
        dataOut  <= inData[0];
        shiftReg <= inData >> 1;
        bitIdx   <= '0;
        lastFlag <= inLast;
      end
      if (stb.clkRise) clkOut <= 1'b1;
      if (stb.clkFall) clkOut <= 1'b0;
      if (stb.shiftBit) begin
        dataOut  <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
        bitIdx   <= bitIdx + 1'b1;
      end
      if (stb.dataClear) begin
        dataOut <= 1'b0;
        clkOut  <= 1'b0;
      end
    end
  end

  assign lastBit = (bitIdx == IDX_W'(BYTE_W - 1));

endmodule

// File: rtl/ps_cfg_ctrl.sv
module ps_cfg_ctrl
  import ps_cfg_pkg::*;
#(
  parameter int RESET_LOW_US  = 40,
  parameter int RESET_WAIT_US = 40,
  parameter int SETTLE_US     = 1,
  parameter int USER_WAIT_US  = 40,
  parameter int UNLOAD_US     = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       startReq,
  input  logic       unloadReq,
  input  logic       inValid,
  input  logic       statusIn,
  input  logic       doneIn,
  input  logic       lastFlag,
  input  logic       lastBit,
  output pinStrobe_t stb,
  output logic       inReady,
  output logic       busy,
  output logic       configured,
  output logic [1:0] errCode
);
  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_US = maxOf(maxOf(maxOf(RESET_LOW_US, RESET_WAIT_US),
                                      maxOf(SETTLE_US, USER_WAIT_US)), UNLOAD_US);
  localparam int CNT_W  = $clog2(MAX_US + 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, limit;
  logic             timeUp;
  logic             errSet, errClr, cfgSet, cfgClr;
  errCode_t         errVal;

  always_comb begin
    case (state)
      S_RST_LOW:   limit = CNT_W'(RESET_LOW_US);
      S_RST_WAIT:  limit = CNT_W'(RESET_WAIT_US);
      S_SETTLE:    limit = CNT_W'(SETTLE_US);
      S_USER_WAIT: limit = CNT_W'(USER_WAIT_US);
      S_UNLOAD:    limit = CNT_W'(UNLOAD_US);
      default:     limit = CNT_W'(1);
    endcase
  end

  assign timeUp = usTick && (cnt == limit - 1'b1);

  always_comb begin
    stb       = '0;
    stateNext = state;
    inReady   = 1'b0;
    errSet    = 1'b0;
    errClr    = 1'b0;
    errVal    = ERR_NONE;
    cfgSet    = 1'b0;
    cfgClr    = 1'b0;
    case (state)
      S_IDLE: begin
        if (startReq) begin
          stb.driveOn     = 1'b1;
          stb.resetAssert = 1'b1;
          stb.dataClear   = 1'b1;
          errClr          = 1'b1;
          cfgClr          = 1'b1;
          stateNext       = S_RST_LOW;
        end else if (unloadReq) begin
          stb.driveOn     = 1'b1;
          stb.resetAssert = 1'b1;
          cfgClr          = 1'b1;
          stateNext       = S_UNLOAD;
        end
      end
      S_RST_LOW: if (timeUp) begin
        stb.resetRelease = 1'b1;
        stateNext        = S_RST_WAIT;
      end
      S_RST_WAIT: if (timeUp) stateNext = S_STAT_CHK;
      S_STAT_CHK: begin
        if (statusIn) stateNext = S_FETCH;
        else begin
          errSet    = 1'b1;
          errVal    = ERR_RESET;
          stateNext = S_IDLE;
        end
      end
      S_FETCH: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.loadByte = 1'b1;
          stateNext    = S_BIT_HIGH;
        end
      end
      S_BIT_HIGH: begin
        stb.clkRise = 1'b1;
        stateNext   = S_BIT_LOW;
      end
      S_BIT_LOW: begin
        stb.clkFall = 1'b1;
        if (lastBit) stateNext = S_BYTE_CHK;
        else begin
          stb.shiftBit = 1'b1;
          stateNext    = S_BIT_HIGH;
        end
      end
      S_BYTE_CHK: begin
        if (!statusIn) begin
          errSet    = 1'b1;
          errVal    = ERR_STATUS;
          stateNext = S_IDLE;
        end else if (lastFlag) begin
          stb.dataClear = 1'b1;
          stateNext     = S_SETTLE;
        end else stateNext = S_FETCH;
      end
      S_SETTLE: if (timeUp) stateNext = S_DONE_CHK;
      S_DONE_CHK: begin
        if (doneIn) stateNext = S_USER_WAIT;
        else begin
          errSet    = 1'b1;
          errVal    = ERR_DONE;
          stateNext = S_IDLE;
        end
      end
      S_USER_WAIT: if (timeUp) begin
        cfgSet    = 1'b1;
        stateNext = S_IDLE;
      end
      S_UNLOAD: if (timeUp) begin
        stb.tristate = 1'b1;
        stateNext    = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cnt        <= '0;
      configured <= 1'b0;
      errCode    <= ERR_NONE;
    end else begin
      state <= stateNext;
      cnt   <= (stateNext != state) ? '0 : cnt + CNT_W'(usTick);
      if (cfgClr) configured <= 1'b0;
      if (cfgSet) configured <= 1'b1;
      if (errClr) errCode <= ERR_NONE;
      if (errSet) errCode <= errVal;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
  import ps_cfg_pkg::*;
#(
  parameter int BYTE_W        = 8,
  parameter int RESET_LOW_US  = 40,
  parameter int RESET_WAIT_US = 40,
  parameter int SETTLE_US     = 1,
  parameter int USER_WAIT_US  = 40,
  parameter int UNLOAD_US     = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              startReq,
  input  logic              unloadReq,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  input  logic              statusIn,
  input  logic              doneIn,
  output logic              cfgResetN,
  output logic              dataOut,
  output logic              clkOut,
  output logic              pinOe,
  output logic              busy,
  output logic              configured,
  output logic [1:0]        errCode
);
  pinStrobe_t stb;
  logic       lastFlag, lastBit;

  ps_cfg_ctrl #(
    .RESET_LOW_US (RESET_LOW_US),
    .RESET_WAIT_US(RESET_WAIT_US),
    .SETTLE_US    (SETTLE_US),
    .USER_WAIT_US (USER_WAIT_US),
    .UNLOAD_US    (UNLOAD_US)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .usTick(usTick), .startReq(startReq),
    .unloadReq(unloadReq), .inValid(inValid), .statusIn(statusIn),
    .doneIn(doneIn), .lastFlag(lastFlag), .lastBit(lastBit), .stb(stb),
    .inReady(inReady), .busy(busy), .configured(configured), .errCode(errCode)
  );

  ps_cfg_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .inLast(inLast),
    .cfgResetN(cfgResetN), .dataOut(dataOut), .clkOut(clkOut), .pinOe(pinOe),
    .lastFlag(lastFlag), .lastBit(lastBit)
  );

endmodule

// File: rtl/ps_cfg_checker.sv
module ps_cfg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       clkOut,
  input logic       dataOut,
  input logic       cfgResetN,
  input logic       pinOe,
  input logic       inReady,
  input logic       configured,
  input logic [1:0] errCode
);
  // R4: serial clock high for one cycle only
  a_r4_clk_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    clkOut |=> !clkOut);

  // R4: data set up before the rising clock edge
  a_r4_data_setup: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkOut) |-> $stable(dataOut));

  // R5: no byte accepted while a bit is on the link
  a_r5_ready_not_shifting: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !clkOut);

  // R9: reset only asserted while the pins are driven
  a_r9_reset_driven: assert property (@(posedge clk) disable iff (!rstN)
    !cfgResetN |-> pinOe);

  // R8: configured implies a clean run
  a_r8_configured_ok: assert property (@(posedge clk) disable iff (!rstN)
    configured |-> (errCode == 2'd0));

  // R7: data parked low once configured
  a_r7_data_parked: assert property (@(posedge clk) disable iff (!rstN)
    $rose(configured) |-> (!dataOut && !clkOut));
endmodule

bind ps_cfg_loader ps_cfg_checker u_chk (.*);

// File: tb/tb_ps_cfg_loader.sv
`timescale 1ns/1ps
module tb_ps_cfg_loader;
  logic clk = 1'b0, rstN = 1'b0, usTick = 1'b0;
  logic startReq = 1'b0, unloadReq = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inLast = 1'b0;
  logic statusIn = 1'b1, doneIn = 1'b0;
  logic inReady, cfgResetN, dataOut, clkOut, pinOe, busy, configured;
  logic [1:0] errCode;

  int checks = 0, failures = 0;

  ps_cfg_loader dut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .startReq(startReq),
    .unloadReq(unloadReq), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .statusIn(statusIn), .doneIn(doneIn),
    .cfgResetN(cfgResetN), .dataOut(dataOut), .clkOut(clkOut), .pinOe(pinOe),
    .busy(busy), .configured(configured), .errCode(errCode)
  );

  always #2 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(posedge clk);
      #1 usTick = 1'b1;
      @(posedge clk);
      #1 usTick = 1'b0;
    end
  end

  // target-side monitor
  logic monClear = 1'b0;
  int lowTicks, waitTicks, postTicks, postRec, capCount, capBits;
  int readyWhileShift, resetFalls, handshakes;
  bit waitArm;
  logic [7:0] capShift;
  logic [7:0] capBytes [0:31];
  logic prevClk = 1'b0, prevRst = 1'b1, prevCfg = 1'b0;

  always @(negedge clk) begin
    if (monClear) begin
      lowTicks = 0; waitTicks = 0; postTicks = 0; postRec = -1;
      capCount = 0; capBits = 0; readyWhileShift = 0; resetFalls = 0;
      handshakes = 0; waitArm = 1'b0; capShift = '0;
    end else begin
      if (!cfgResetN && usTick) lowTicks++;
      if (!cfgResetN && prevRst) resetFalls++;
      if (cfgResetN && !prevRst) begin
        waitTicks = usTick ? 1 : 0; waitArm = 1'b1;
      end else if (waitArm && inReady) waitArm = 1'b0;
      else if (waitArm && usTick) waitTicks++;
      if (clkOut && !prevClk) begin
        capShift = {dataOut, capShift[7:1]};
        capBits++;
        if (capBits == 8) begin
          if (capCount < 32) capBytes[capCount] = capShift;
          capCount++; capBits = 0;
        end
      end
      if (configured && !prevCfg) postRec = postTicks;
      else if (prevClk && !clkOut) postTicks = usTick ? 1 : 0;
      else if (!configured && usTick) postTicks++;
      if (inReady && clkOut) readyWhileShift++;
      if (inReady && inValid) handshakes++;
    end
    prevClk = clkOut; prevRst = cfgResetN; prevCfg = configured;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    @(posedge clk); #1 monClear = 1'b1;
    @(posedge clk); #1 monClear = 1'b0;
  endtask

  task automatic pulseStart();
    @(posedge clk); #1 startReq = 1'b1;
    @(posedge clk); #1 startReq = 1'b0;
  endtask

  task automatic pulseUnload();
    @(posedge clk); #1 unloadReq = 1'b1;
    @(posedge clk); #1 unloadReq = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic feedOne(input logic [7:0] d, input logic l, output bit ok);
    @(posedge clk); #1 inData = d; inLast = l; inValid = 1'b1;
    @(negedge clk);
    while (!inReady && busy) @(negedge clk);
    ok = inReady;
    @(posedge clk); #1 inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(pinOe == 1'b0 && cfgResetN == 1'b1, "R1 pins", {pinOe, cfgResetN}, 1);
    check(!busy && !inReady && !configured, "R1 status", {busy, inReady, configured}, 0);
    check(errCode == 2'd0, "R1 errCode", errCode, 0);
  endtask

  task automatic testNormal();
    logic [7:0] b [0:2];
    bit ok;
    b[0] = 8'hA5; b[1] = 8'h01; b[2] = 8'h80;
    clearMon(); statusIn = 1'b1; doneIn = 1'b0;
    pulseStart();
    for (int i = 0; i < 3; i++) begin
      repeat (i) @(posedge clk);
      feedOne(b[i], i == 2, ok);
    end
    doneIn = 1'b1;
    waitIdle();
    @(negedge clk);
    check(lowTicks == 40, "R2 reset low ticks", lowTicks, 40);
    check(waitTicks == 40, "R2 reset wait ticks", waitTicks, 40);
    check(capCount == 3, "R5 byte count", capCount, 3);
    for (int i = 0; i < 3; i++)
      check(capBytes[i] == b[i], "R4 LSB-first byte", capBytes[i], b[i]);
    check(readyWhileShift == 0, "R5 ready while shifting", readyWhileShift, 0);
    check(configured && errCode == 2'd0, "R8 configured ok", {configured, errCode}, 4);
    check(postRec >= 41 && postRec <= 42, "R8 post done ticks", postRec, 41);
    check(dataOut == 1'b0 && clkOut == 1'b0, "R7 data parked low", {dataOut, clkOut}, 0);
  endtask

  task automatic testUnload();
    clearMon();
    pulseUnload();
    @(negedge clk);
    check(pinOe && !cfgResetN && busy, "R9 unload drives reset", {pinOe, cfgResetN, busy}, 5);
    check(!configured, "R9 configured cleared", configured, 0);
    waitIdle();
    check(lowTicks == 40, "R9 unload low ticks", lowTicks, 40);
    check(pinOe == 1'b0, "R9 pins released", pinOe, 0);
  endtask

  task automatic testResetFail();
    clearMon(); statusIn = 1'b0;
    pulseStart();
    waitIdle();
    check(errCode == 2'd1, "R3 reset failure code", errCode, 1);
    check(handshakes == 0 && capCount == 0, "R3 no byte accepted", handshakes, 0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(errCode == 2'd1, "R10 error held", errCode, 1);
    statusIn = 1'b1;
  endtask

  task automatic testStatusLost();
    bit ok;
    clearMon(); statusIn = 1'b1; doneIn = 1'b1;
    pulseStart();
    feedOne(8'h3C, 1'b0, ok);
    feedOne(8'hC3, 1'b0, ok);
    statusIn = 1'b0;
    feedOne(8'h77, 1'b1, ok);
    waitIdle();
    check(errCode == 2'd2, "R6 status lost code", errCode, 2);
    check(!ok && handshakes == 2, "R6 no byte after loss", handshakes, 2);
    check(capCount == 2 && capBytes[1] == 8'hC3, "R6 bytes shifted", capCount, 2);
    check(!configured, "R6 not configured", configured, 0);
    statusIn = 1'b1;
  endtask

  task automatic testDoneMissing();
    bit ok;
    clearMon(); doneIn = 1'b0;
    pulseStart();
    feedOne(8'h12, 1'b0, ok);
    feedOne(8'h34, 1'b1, ok);
    waitIdle();
    check(errCode == 2'd3, "R7 done missing code", errCode, 3);
    check(!configured, "R7 not configured", configured, 0);
    check(dataOut == 1'b0, "R7 data low", dataOut, 0);
  endtask

  task automatic testBusyIgnore();
    bit ok;
    clearMon(); doneIn = 1'b1;
    pulseStart();
    @(negedge clk);
    check(errCode == 2'd0, "R10 error cleared on start", errCode, 0);
    feedOne(8'h5A, 1'b0, ok);
    pulseStart();
    feedOne(8'hF0, 1'b0, ok);
    pulseUnload();
    feedOne(8'h0F, 1'b0, ok);
    feedOne(8'h99, 1'b1, ok);
    waitIdle();
    check(resetFalls == 1, "R10 start ignored while busy", resetFalls, 1);
    check(capCount == 4 && capBytes[3] == 8'h99, "R10 run unaffected", capCount, 4);
    check(configured && pinOe, "R10 unload ignored while busy", {configured, pinOe}, 3);
  endtask

  task automatic testLong();
    bit ok;
    int bad = 0;
    clearMon(); doneIn = 1'b1;
    pulseStart();
    for (int i = 0; i < 16; i++) begin
      repeat (3) @(posedge clk);
      feedOne(8'(i * 17 + 3), i == 15, ok);
    end
    waitIdle();
    for (int i = 0; i < 16; i++)
      if (capBytes[i] != 8'(i * 17 + 3)) bad++;
    check(capCount == 16, "R5 long stream count", capCount, 16);
    check(bad == 0, "R4 long stream bytes", bad, 0);
    check(configured && errCode == 2'd0, "R8 long stream ok", errCode, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testNormal();
    testUnload();
    testResetFail();
    testStatusLost();
    testDoneMissing();
    testBusyIgnore();
    testLong();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule